// File: doc/BRIEF.md
# Block-Error Maintenance Status

This block produces the far-end and near-end block-error maintenance bits for a line interface built on superframes. Once per superframe it takes the CRC check result of the superframe just received, together with the far-end block error bit carried in that superframe. From these it keeps a computed near-end error status, a latched copy of the received far-end bit and two saturating performance counters. It also forms the far-end error bit that goes back out to the far end.

Timing comes from three single-cycle strobes: the end of basic frame 2 (the transmit point), the end of basic frame 8 (where software refreshes its input bit) and the end of the superframe. All status is valid only while both superframe sync and linkup are up. A control input selects how the outgoing bit is formed. Software can drive it directly, or the software bit can be merged with the local CRC result. In both cases the bits are active low.

Top module: `blk_err_status`

## Requirements
- R1: At a superframe-end strobe with sync and linkup both high, `nebe_o` becomes 0 if `crc_err_i` is 1 and 1 if it is 0, one cycle after the strobe; otherwise it holds.
- R2: In any cycle where `sf_sync_i` or `linkup_i` is low, `nebe_o` is 0 from the next cycle on.
- R3: `rx_febe_o` takes `rx_febe_i` at a superframe-end strobe only when sync and linkup are both high, and holds in every other cycle.
- R4: With `febe_force_i` = 1 at a frame-8 strobe, the bit queued for transmission is `sw_febe_i`.
- R5: With `febe_force_i` = 0 at a frame-8 strobe, the bit queued is 0 (active) when `nebe_o` or `sw_febe_i` is 0, and 1 otherwise.
- R6: The queued bit appears on `tx_febe_o` one cycle after the next frame-2 strobe and is held between frame-2 strobes. Frame-8 strobes do not change `tx_febe_o`.
- R7: At a superframe-end strobe with sync and linkup high, `febe_cnt_o` increments when `rx_febe_i` is 0 and `nebe_cnt_o` increments when `crc_err_i` is 1. Neither counter moves when sync or linkup is low.
- R8: Each counter is 8 bits wide and stops at 255.
- R9: `cnt_clr_i` zeroes both counters on the next cycle, even when an increment would happen in the same cycle.
- R10: After reset, `nebe_o` is 0, `rx_febe_o` is 1, `tx_febe_o` is 1, the queued bit is 1 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bf2_end_i | input | 1 | Strobe at the end of basic frame 2 (transmit point) |
| bf8_end_i | input | 1 | Strobe at the end of basic frame 8 (sampling point) |
| sf_end_i | input | 1 | Strobe at the end of the superframe |
| crc_err_i | input | 1 | CRC error of the superframe, valid with `sf_end_i` |
| rx_febe_i | input | 1 | Received far-end error bit, valid with `sf_end_i` |
| sf_sync_i | input | 1 | Superframe sync status |
| linkup_i | input | 1 | Linkup status |
| sw_febe_i | input | 1 | Software far-end error bit, active low |
| febe_force_i | input | 1 | 1: transmit the software bit as is; 0: merge it with the local CRC result |
| cnt_clr_i | input | 1 | Clear both counters |
| nebe_o | output | 1 | Computed near-end error status (0 = error) |
| rx_febe_o | output | 1 | Latched received far-end error bit |
| tx_febe_o | output | 1 | Outgoing far-end error bit |
| febe_cnt_o | output | 8 | Far-end error counter |
| nebe_cnt_o | output | 8 | Near-end error counter |

## Verification
The bench drops sync and linkup between superframe strobes. A design that gated only at the strobe would leave a stale `nebe_o` of 1, or would still latch and count. It places the frame-8 strobe of a superframe after a CRC error, so a merge that used OR or that ignored `nebe_o` sends the wrong bit. It also checks that nothing reaches `tx_febe_o` before frame 2. It runs a counter past 255 to catch wrap-around, and it asserts a clear together with a counting strobe to catch increment-over-clear priority.

// File: rtl/blk_err_pkg.sv
package blk_err_pkg;
  localparam int CNT_W    = 8;
  localparam int NUM_CNT  = 2;
  localparam int IDX_FEBE = 0;
  localparam int IDX_NEBE = 1;
endpackage

// File: rtl/err_sat_counter.sv
module err_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxVal = {W{1'b1}};

  logic at_max;
  assign at_max = (cnt_o == MaxVal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (inc_i && !at_max)  cnt_o <= cnt_o + 1'b1;
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && !clr_i) |=> (cnt_o == MaxVal));
  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
  assert_step_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rx_status.sv
module rx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sf_end_i,
  input  logic link_ok_i,
  input  logic crc_err_i,
  input  logic rx_febe_i,
  output logic nebe_o,
  output logic rx_febe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        nebe_o <= 1'b0;
    else if (!link_ok_i) nebe_o <= 1'b0;
    else if (sf_end_i)  nebe_o <= ~crc_err_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rx_febe_o <= 1'b1;
    else if (sf_end_i && link_ok_i)  rx_febe_o <= rx_febe_i;
  end

  assert_nebe_forced_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_i |=> !nebe_o);
  assert_nebe_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_ok_i && !sf_end_i) |=> $stable(nebe_o));
  assert_rx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sf_end_i && link_ok_i) |=> $stable(rx_febe_o));
endmodule

// File: rtl/tx_febe_path.sv
module tx_febe_path (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bf8_end_i,
  input  logic bf2_end_i,
  input  logic force_i,
  input  logic sw_febe_i,
  input  logic nebe_i,
  output logic tx_febe_o
);
  logic queued_q;
  logic merged;

  // active low: either source at 0 marks an error
  assign merged = force_i ? sw_febe_i : (sw_febe_i & nebe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        queued_q <= 1'b1;
    else if (bf8_end_i) queued_q <= merged;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_febe_o <= 1'b1;
    else if (bf2_end_i) tx_febe_o <= queued_q;
  end

  assert_tx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bf2_end_i |=> $stable(tx_febe_o));
  assert_force_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bf8_end_i && force_i) |=> (queued_q == $past(sw_febe_i)));
  assert_merge_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bf8_end_i && !force_i && !nebe_i) |=> !queued_q);
endmodule

// File: rtl/blk_err_status.sv
module blk_err_status
  import blk_err_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bf2_end_i,
  input  logic             bf8_end_i,
  input  logic             sf_end_i,
  input  logic             crc_err_i,
  input  logic             rx_febe_i,
  input  logic             sf_sync_i,
  input  logic             linkup_i,
  input  logic             sw_febe_i,
  input  logic             febe_force_i,
  input  logic             cnt_clr_i,
  output logic             nebe_o,
  output logic             rx_febe_o,
  output logic             tx_febe_o,
  output logic [CNT_W-1:0] febe_cnt_o,
  output logic [CNT_W-1:0] nebe_cnt_o
);
  logic link_ok;
  assign link_ok = sf_sync_i & linkup_i;

  rx_status u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sf_end_i  (sf_end_i),
    .link_ok_i (link_ok),
    .crc_err_i (crc_err_i),
    .rx_febe_i (rx_febe_i),
    .nebe_o    (nebe_o),
    .rx_febe_o (rx_febe_o)
  );

  tx_febe_path u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bf8_end_i (bf8_end_i),
    .bf2_end_i (bf2_end_i),
    .force_i   (febe_force_i),
    .sw_febe_i (sw_febe_i),
    .nebe_i    (nebe_o),
    .tx_febe_o (tx_febe_o)
  );

  logic [NUM_CNT-1:0] evt;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  assign evt[IDX_FEBE] = sf_end_i & link_ok & ~rx_febe_i;
  assign evt[IDX_NEBE] = sf_end_i & link_ok & crc_err_i;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    err_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cnt_clr_i),
      .inc_i  (evt[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign febe_cnt_o = cnt[IDX_FEBE];
  assign nebe_cnt_o = cnt[IDX_NEBE];

  assert_no_count_unlinked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_ok && !cnt_clr_i) |=> ($stable(febe_cnt_o) && $stable(nebe_cnt_o)));
endmodule

// File: tb/sim_blk_err_status.sv
module sim_blk_err_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic bf2 = 0, bf8 = 0, sfe = 0, crc = 0, rxf = 1, sync = 0, link = 0;
  logic sw = 1, frc = 0, clr = 0;
  logic nebe, rxfo, txf;
  logic [7:0] fcnt, ncnt;

  blk_err_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .bf2_end_i(bf2), .bf8_end_i(bf8), .sf_end_i(sfe),
    .crc_err_i(crc), .rx_febe_i(rxf), .sf_sync_i(sync), .linkup_i(link),
    .sw_febe_i(sw), .febe_force_i(frc), .cnt_clr_i(clr),
    .nebe_o(nebe), .rx_febe_o(rxfo), .tx_febe_o(txf),
    .febe_cnt_o(fcnt), .nebe_cnt_o(ncnt)
  );

  typedef struct {
    string      tag;
    logic       nebe, rxf, tx;
    logic [7:0] fc, nc;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic m_nebe = 0, m_rxf = 1, m_sel = 1, m_tx = 1;
  logic [7:0] m_fc = 0, m_nc = 0;

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  // monitor: pops expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "nebe_o", nebe, e.nebe);
      chk(e.tag, "rx_febe_o", rxfo, e.rxf);
      chk(e.tag, "tx_febe_o", txf, e.tx);
      chk(e.tag, "febe_cnt_o", fcnt, e.fc);
      chk(e.tag, "nebe_cnt_o", ncnt, e.nc);
    end
  end

  // driver: one clock with current inputs, model update, push expectation
  task automatic step(string tag);
    logic ok, n_nebe, n_sel, n_tx;
    exp_t e;
    ok = sync & link;
    n_nebe = !ok ? 1'b0 : (sfe ? ~crc : m_nebe);
    n_sel = bf8 ? (frc ? sw : (sw & m_nebe)) : m_sel;
    n_tx = bf2 ? m_sel : m_tx;
    if (sfe && ok) m_rxf = rxf;
    if (clr) begin m_fc = 0; m_nc = 0; end
    else if (sfe && ok) begin
      if (!rxf && m_fc != 8'hff) m_fc++;
      if (crc && m_nc != 8'hff) m_nc++;
    end
    m_nebe = n_nebe; m_sel = n_sel; m_tx = n_tx;
    @(posedge clk);
    #1;
    e.tag = tag; e.nebe = m_nebe; e.rxf = m_rxf; e.tx = m_tx; e.fc = m_fc; e.nc = m_nc;
    q.push_back(e);
    @(negedge clk);
    bf2 = 0; bf8 = 0; sfe = 0; clr = 0;
  endtask

  // one superframe: frame 2, frame 8, end
  task automatic superframe(string tag, logic c, logic r, logic s);
    step(tag);
    bf2 = 1; step(tag);
    step(tag);
    sw = s; bf8 = 1; step(tag);
    step(tag);
    crc = c; rxf = r; sfe = 1; step(tag);
    crc = 0; rxf = 1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    begin
      exp_t e;
      e.tag = "R10"; e.nebe = 0; e.rxf = 1; e.tx = 1; e.fc = 0; e.nc = 0;
      q.push_back(e);
    end
    @(negedge clk);
    rst_n = 1;
    step("R10");
    sync = 1; link = 1;
    superframe("R1", 0, 1, 1);   // nebe -> 1
    superframe("R1", 1, 0, 1);   // crc err, rx febe 0, counts
    superframe("R5", 0, 1, 1);   // bf8 saw nebe=0 -> queued 0
    superframe("R6", 0, 1, 1);   // transmitted 0 at frame 2
    superframe("R5", 0, 1, 0);   // sw active -> queued 0
    superframe("R5", 0, 1, 1);
    frc = 1;
    superframe("R4", 1, 1, 0);
    superframe("R4", 0, 1, 1);   // nebe 0 ignored in force mode
    superframe("R4", 0, 1, 1);
    frc = 0;
    // sync lost mid-superframe
    step("R2");
    sync = 0; step("R2");
    crc = 0; rxf = 0; sfe = 1; step("R3");
    step("R7");
    sync = 1; link = 0;
    crc = 1; rxf = 0; sfe = 1; step("R3");
    link = 1; step("R2");
    superframe("R1", 0, 1, 1);
    bf8 = 1; step("R6");     // frame-8 only: tx unchanged
    step("R6");
    // clear together with counting strobe
    crc = 1; rxf = 0; sfe = 1; clr = 1; step("R9");
    crc = 0; rxf = 1;
    // saturation
    for (int i = 0; i < 260; i++) begin
      crc = 1; rxf = 0; sfe = 1; step("R8");
    end
    crc = 0; rxf = 1;
    step("R8");
    clr = 1; step("R9");
    step("R9");
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 20000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule